// File: doc/BRIEF.md
# Split Read Request Decomposer

This block sits on the forwarding path of a bus bridge and takes one large read request at a time: a start address, a byte count and the original requester tag. A commitment limit in kilobytes is sampled when the request is accepted and sets the forwarding mode. If the limit is below 32 KB, the request is cut into sub-requests of at most 512 bytes. If the limit is 32 KB or more, the request goes out whole. Every forwarded request carries a fresh tag taken from a 5-bit wrapping counter.

Sub-requests are strictly serialised. Once one is accepted downstream, the next is held back until completion beats totalling its byte count have arrived. When the last sub-request has been fully answered, a one-cycle done pulse returns the original tag. A new original request can be accepted in that same done cycle.

The control is a four-state machine:
- IDLE: waiting for a request.
- ISSUE: presenting a sub-request.
- WAIT: counting completion bytes.
- DONE: signalling completion.

The transitions are:
- IDLE to ISSUE on accept.
- ISSUE to WAIT on the downstream handshake.
- WAIT to ISSUE when a sub-request is satisfied and bytes remain.
- WAIT to DONE when it is satisfied and nothing remains.
- DONE to ISSUE on a chained accept.
- DONE to IDLE otherwise.

Top module: `rdreq_splitter`

## Requirements
- R1: `req_ready` is high only in the idle and done states, and a request is taken on a cycle where `req_valid` and `req_ready` are both high.
- R2: With `commit_kb` of 32 or more at acceptance, exactly one sub-request is forwarded, carrying the original address and byte count.
- R3: With `commit_kb` below 32 (values below 4 included), sub-requests carry min(remaining, 512) bytes. Each one starts at the previous address plus the previous byte count, and ceil(bytes/512) of them are issued.
- R4: After a sub-request handshake, `sub_valid` stays low until completion beats summing to that sub-request's byte count have been taken. If more bytes remain, it rises in the cycle after the final beat.
- R5: While `sub_valid` is high and `sub_ready` is low, `sub_addr`, `sub_bytes` and `sub_tag` hold steady.
- R6: `sub_tag` comes from a 5-bit counter that is 0 after reset and advances by one, modulo 32, on each sub-request handshake.
- R7: `done` is a single-cycle pulse in the cycle after the final beat of the last sub-request, and `done_tag` then equals the original `req_tag`.
- R8: A request offered during the done cycle is accepted there, and its first sub-request is presented in the next cycle.
- R9: During and directly after reset, `req_ready` is 1, `sub_valid` is 0 and `done` is 0.
- R10: Completion beats that arrive while no sub-request is outstanding (idle, or before the handshake) are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| commit_kb | input | LIM_W | Commitment limit in KB, sampled at accept |
| req_valid | input | 1 | Original request offered |
| req_ready | output | 1 | Original request can be taken |
| req_addr | input | ADDR_W | Original start address |
| req_bytes | input | BC_W | Original byte count, 1 to 4096 |
| req_tag | input | TAG_W | Original requester tag |
| sub_valid | output | 1 | Sub-request presented |
| sub_ready | input | 1 | Sub-request taken downstream |
| sub_addr | output | ADDR_W | Sub-request start address |
| sub_bytes | output | BC_W | Sub-request byte count |
| sub_tag | output | TAG_W | Freshly generated tag |
| cpl_valid | input | 1 | Completion beat present |
| cpl_bytes | input | BC_W | Bytes carried by the beat |
| done | output | 1 | Original request satisfied |
| done_tag | output | TAG_W | Original tag of the finished request |

## Verification
Two events can fall in the same cycle: the done pulse that closes one request, and the acceptance of the next request. The bench provokes this by raising `req_valid` in the done cycle on every other request of the sweep. It then judges that the next request's first sub-request appears one cycle later, with the correct address, the correct size and the next tag in sequence. A second collision is also provoked: stray completion beats arrive while a sub-request is still waiting for `sub_ready`. The bench confirms they are dropped, because the next sub-request or the done pulse appears only after the full byte count has been sent in later beats.

// File: rtl/rds_pkg.sv
package rds_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } rds_state_e;
endpackage

// File: rtl/rds_chunker.sv
// Picks the size of the next sub-request from the bytes still to issue.
module rds_chunker #(
    parameter int BC_W  = 13,
    parameter int CHUNK = 512
) (
    input  logic [BC_W-1:0] remain,
    input  logic            split,
    output logic [BC_W-1:0] size
);
    localparam logic [BC_W-1:0] CAP = BC_W'(CHUNK);

    always_comb begin
        if (split && (remain > CAP)) size = CAP;
        else                         size = remain;
    end
endmodule

// File: rtl/rds_tag_gen.sv
// Wrapping counter that supplies a fresh tag per forwarded request.
module rds_tag_gen #(
    parameter int TAG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [TAG_W-1:0] tag
);
    always_ff @(posedge clk) begin
        if (!rst_n)    tag <= '0;
        else if (step) tag <= tag + 1'b1;
    end
endmodule

// File: rtl/rds_cpl_tracker.sv
// Sums completion bytes for the outstanding sub-request.
module rds_cpl_tracker #(
    parameter int BC_W = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            acc,
    input  logic [BC_W-1:0] beat,
    input  logic [BC_W-1:0] target,
    output logic            reach
);
    localparam int CW = BC_W + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] sum;

    always_comb begin
        sum   = cnt + (acc ? CW'(beat) : '0);
        reach = acc && (sum >= CW'(target));
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (acc)      cnt <= sum;
    end
endmodule

// File: rtl/rdreq_splitter.sv
module rdreq_splitter
    import rds_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int BC_W     = 13,
    parameter int TAG_W    = 5,
    parameter int LIM_W    = 7,
    parameter int CHUNK    = 512,
    parameter int WHOLE_KB = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LIM_W-1:0]  commit_kb,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BC_W-1:0]   req_bytes,
    input  logic [TAG_W-1:0]  req_tag,
    output logic              sub_valid,
    input  logic              sub_ready,
    output logic [ADDR_W-1:0] sub_addr,
    output logic [BC_W-1:0]   sub_bytes,
    output logic [TAG_W-1:0]  sub_tag,
    input  logic              cpl_valid,
    input  logic [BC_W-1:0]   cpl_bytes,
    output logic              done,
    output logic [TAG_W-1:0]  done_tag
);
    localparam logic [LIM_W-1:0] WHOLE_LIM = LIM_W'(WHOLE_KB);

    rds_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [BC_W-1:0]   remain_q;
    logic [BC_W-1:0]   size_q;
    logic [BC_W-1:0]   size_next;
    logic [TAG_W-1:0]  orig_tag_q;
    logic [TAG_W-1:0]  tag_q;
    logic              split_q;
    logic              accept, fire, reach;

    assign accept = req_valid && req_ready;
    assign fire   = sub_valid && sub_ready;

    rds_chunker #(.BC_W(BC_W), .CHUNK(CHUNK)) i_chunker (
        .remain (remain_q),
        .split  (split_q),
        .size   (size_next)
    );

    rds_tag_gen #(.TAG_W(TAG_W)) i_tag (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (fire),
        .tag   (tag_q)
    );

    rds_cpl_tracker #(.BC_W(BC_W)) i_trk (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (fire),
        .acc    (cpl_valid && (state_q == ST_WAIT)),
        .beat   (cpl_bytes),
        .target (size_q),
        .reach  (reach)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_ISSUE;
            ST_ISSUE: if (sub_ready) state_d = ST_WAIT;
            ST_WAIT:  if (reach)     state_d = (remain_q == '0) ? ST_DONE : ST_ISSUE;
            ST_DONE:  state_d = req_valid ? ST_ISSUE : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready = 1'b0;
        sub_valid = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_ISSUE: sub_valid = 1'b1;
            ST_WAIT:  ;
            ST_DONE:  begin req_ready = 1'b1; done = 1'b1; end
            default:  ;
        endcase
    end

    assign sub_addr  = addr_q;
    assign sub_bytes = size_next;
    assign sub_tag   = tag_q;
    assign done_tag  = orig_tag_q;

    // Request datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q     <= '0;
            remain_q   <= '0;
            size_q     <= '0;
            orig_tag_q <= '0;
            split_q    <= 1'b0;
        end else if (accept) begin
            addr_q     <= req_addr;
            remain_q   <= req_bytes;
            orig_tag_q <= req_tag;
            split_q    <= (commit_kb < WHOLE_LIM);
        end else if (fire) begin
            size_q   <= size_next;
            addr_q   <= addr_q + ADDR_W'(size_next);
            remain_q <= remain_q - size_next;
        end
    end
endmodule

// File: rtl/rds_checker.sv
module rds_checker #(
    parameter int ADDR_W = 32,
    parameter int BC_W   = 13,
    parameter int TAG_W  = 5,
    parameter int CHUNK  = 512
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              sub_valid,
    input logic              sub_ready,
    input logic [ADDR_W-1:0] sub_addr,
    input logic [BC_W-1:0]   sub_bytes,
    input logic [TAG_W-1:0]  sub_tag,
    input logic [TAG_W-1:0]  tag_q,
    input logic              split_q,
    input logic              done
);
    AST_SUB_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_valid && split_q) |-> (sub_bytes <= BC_W'(CHUNK)));  // R3
    AST_SUB_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        sub_valid |-> (sub_bytes != '0));  // R2
    AST_SUB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_valid && !sub_ready) |=> (sub_valid && $stable(sub_addr)
                                       && $stable(sub_bytes) && $stable(sub_tag)));  // R5
    AST_TAG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_valid && sub_ready) |=> (tag_q == TAG_W'($past(sub_tag) + 1'b1)));  // R6
    AST_SERIAL: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_valid && sub_ready) |=> !sub_valid);  // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R7
    AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !sub_valid);  // R1
endmodule

bind rdreq_splitter rds_checker #(
    .ADDR_W(ADDR_W), .BC_W(BC_W), .TAG_W(TAG_W), .CHUNK(CHUNK)
) i_rds_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .sub_valid (sub_valid),
    .sub_ready (sub_ready),
    .sub_addr  (sub_addr),
    .sub_bytes (sub_bytes),
    .sub_tag   (sub_tag),
    .tag_q     (tag_q),
    .split_q   (split_q),
    .done      (done)
);

// File: tb/test_rdreq_splitter.sv
module test_rdreq_splitter;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [6:0]  commit_kb;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_addr;
    logic [12:0] req_bytes;
    logic [4:0]  req_tag;
    logic        sub_valid;
    logic        sub_ready;
    logic [31:0] sub_addr;
    logic [12:0] sub_bytes;
    logic [4:0]  sub_tag;
    logic        cpl_valid;
    logic [12:0] cpl_bytes;
    logic        done;
    logic [4:0]  done_tag;

    int n_checks = 0;
    int n_fail   = 0;
    logic [4:0] exp_tag = '0;

    always #2 clk = ~clk;

    rdreq_splitter i_rdreq_splitter (
        .clk(clk), .rst_n(rst_n), .commit_kb(commit_kb),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_bytes(req_bytes), .req_tag(req_tag),
        .sub_valid(sub_valid), .sub_ready(sub_ready), .sub_addr(sub_addr),
        .sub_bytes(sub_bytes), .sub_tag(sub_tag),
        .cpl_valid(cpl_valid), .cpl_bytes(cpl_bytes),
        .done(done), .done_tag(done_tag)
    );

    task automatic chk(input string rq, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    // Drive an original request at the current negedge; returns one cycle later.
    task automatic offer(input logic [31:0] a, input int nb, input logic [4:0] t, input int kb);
        req_valid = 1'b1; req_addr = a; req_bytes = 13'(nb); req_tag = t; commit_kb = 7'(kb);
        chk("R1", "req_ready at offer", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Serve all sub-requests of an accepted request; ends in the done cycle.
    task automatic serve(input logic [31:0] a0, input int nb, input logic [4:0] otag,
                         input int kb, input int pat, input bit chained);
        int rem = nb;
        logic [31:0] a = a0;
        int k = 0;
        bit split = (kb < 32);
        string rq = split ? "R3" : "R2";
        while (rem > 0) begin
            int sz = (split && rem > 512) ? 512 : rem;
            int dly = (pat + k) % 3;
            int bsz;
            int left;
            case ((pat + k) % 4)
                0: bsz = 64;
                1: bsz = 100;
                2: bsz = 512;
                default: bsz = 7;
            endcase
            // R8: first sub-request of a chained request right after done
            chk((chained && k == 0) ? "R8" : rq, "sub_valid", sub_valid, 1);
            chk(rq, "sub_addr", sub_addr, a);
            chk(rq, "sub_bytes", sub_bytes, sz);
            chk("R6", "sub_tag", sub_tag, exp_tag);
            chk("R1", "req_ready while issuing", req_ready, 0);
            for (int d = 0; d < dly; d++) begin
                cpl_valid = 1'b1; cpl_bytes = 13'(sz);   // stray beat, R10
                @(negedge clk);
                chk("R5", "sub_valid held", sub_valid, 1);
                chk("R5", "sub_addr held", sub_addr, a);
                chk("R5", "sub_bytes held", sub_bytes, sz);
            end
            cpl_valid = 1'b0;
            sub_ready = 1'b1;
            @(negedge clk);
            sub_ready = 1'b0;
            exp_tag = exp_tag + 1'b1;
            chk("R4", "sub_valid after handshake", sub_valid, 0);
            left = sz;
            while (left > 0) begin
                int b = (left < bsz) ? left : bsz;
                if (pat % 2 == 1) begin
                    cpl_valid = 1'b0;
                    @(negedge clk);
                    chk("R4", "no issue during gap", sub_valid, 0);
                end
                cpl_valid = 1'b1; cpl_bytes = 13'(b);
                left -= b;
                @(negedge clk);
                if (left > 0) begin
                    chk("R10", "no early issue", sub_valid, 0);
                    chk("R4", "no early done", done, 0);
                end
            end
            cpl_valid = 1'b0;
            rem -= sz;
            a += 32'(sz);
            k++;
        end
        chk("R7", "done", done, 1);
        chk("R7", "done_tag", done_tag, otag);
        chk("R1", "req_ready in done", req_ready, 1);
        chk(rq, "sub-request count", k, split ? (nb + 511) / 512 : 1);
    endtask

    initial begin
        int kbs[8]   = '{0, 3, 4, 20, 31, 32, 33, 64};
        int sizes[9] = '{1, 200, 511, 512, 513, 1000, 1024, 1537, 4096};
        int idx = 0;
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_bytes = '0; req_tag = '0;
        commit_kb = '0; sub_ready = 1'b0; cpl_valid = 1'b0; cpl_bytes = '0;
        repeat (3) @(negedge clk);
        chk("R9", "req_ready in reset", req_ready, 1);
        chk("R9", "sub_valid in reset", sub_valid, 0);
        chk("R9", "done in reset", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", "sub_valid after reset", sub_valid, 0);
        // R10: a stray beat in idle has no effect
        cpl_valid = 1'b1; cpl_bytes = 13'd100;
        @(negedge clk);
        cpl_valid = 1'b0;
        chk("R10", "idle beat sub_valid", sub_valid, 0);
        chk("R10", "idle beat done", done, 0);
        chk("R10", "idle beat req_ready", req_ready, 1);

        foreach (kbs[i]) begin
            foreach (sizes[j]) begin
                logic [31:0] a = 32'h1000_0000 + 32'(idx * 4093);
                logic [4:0]  t = 5'(idx * 7 + 3);
                offer(a, sizes[j], t, kbs[i]);
                serve(a, sizes[j], t, kbs[i], idx, (idx % 2 == 0) && (idx != 0));
                if (idx % 2 == 0) begin
                    @(negedge clk);
                    chk("R7", "done single pulse", done, 0);
                    chk("R1", "ready when idle", req_ready, 1);
                end
                idx++;
            end
        end
        @(negedge clk);
        chk("R7", "final idle done", done, 0);
        summary();
        $finish;
    end
endmodule